// File: doc/BRIEF.md
# Bit-Manipulation and Shift Accumulator

This block holds one word-wide working register and changes it by at most one operation per rising clock edge, and only while the step enable is high. A four-bit operation code selects the change. The register can be loaded in parallel. It can be edited bit by bit under a pattern operand (force to one, flip, force to zero, keep under a mask, difference, field insert with a second value operand). It can also be shifted by one place, either logically, circularly or arithmetically, in either direction.

A left arithmetic shift also reports signed overflow in a registered flag. The flag is set when the two top bits of the register disagree before the shift. Any other operation that is executed clears the flag, and so does reset.

Top module: `bitop_shift_reg`

## Requirements
- R1: Synchronous active-high reset clears the register and the overflow flag on the next rising edge. With the step enable low, neither the register nor the flag changes.
- R2: Opcode 0 loads the parallel input. Opcode 1 gives reg | pat, and opcode 3 gives reg & ~pat.
- R3: Opcode 2 and opcode 5 both give reg ^ pat. Opcode 4 gives reg & pat.
- R4: Opcode 6 gives (reg & pat) | val, which inserts val into the field that pat clears.
- R5: Opcode 7 shifts left with a 0 entering the LSB. Opcode 8 shifts right with a 0 entering the MSB.
- R6: Opcode 9 rotates left, so the old MSB enters the LSB. Opcode 10 rotates right, so the old LSB enters the MSB.
- R7: Opcode 11 shifts left with a 0 entering the LSB. Opcode 12 shifts right and keeps the MSB, which is also copied into the next lower bit.
- R8: After opcode 11 the overflow flag equals the XOR of the two top bits the register held before the shift. Any other executed operation, including an unused opcode, clears the flag.
- R9: Opcodes 13 to 15 leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Enables one operation on this edge |
| op_code | input | 4 | Operation select |
| load_val | input | WIDTH | Parallel load data |
| pat | input | WIDTH | Pattern or mask operand |
| ins_val | input | WIDTH | Bits to insert (opcode 6) |
| acc | output | WIDTH | Register contents |
| ovf | output | 1 | Registered overflow flag of the left arithmetic shift |

## Verification
The bench aims at the bits that move across the ends of the word. A rotate that drops the wrapped bit would look like a logical shift. An arithmetic right shift that shifts in zero would turn negative values positive. The overflow flag is tested on values whose top two bits are equal and on values where they differ, followed by a different operation. A flag that is computed from the result, or that is never cleared, shows up there. The bench also applies unused opcodes and cycles with the enable low, to catch a register that drifts when it should hold.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [3:0] {
    OP_LOAD = 4'd0, OP_SET = 4'd1, OP_FLIP = 4'd2, OP_CLR = 4'd3,
    OP_MASK = 4'd4, OP_DIFF = 4'd5, OP_INS = 4'd6, OP_SHL = 4'd7,
    OP_SHR = 4'd8, OP_ROL = 4'd9, OP_ROR = 4'd10, OP_ASL = 4'd11,
    OP_ASR = 4'd12
  } op_e;

  typedef enum logic [1:0] { FILL_ZERO, FILL_WRAP, FILL_SIGN } fill_e;
endpackage

// File: rtl/bitop_logic_unit.sv
module bitop_logic_unit #(
  parameter int WIDTH = 16
) (
  input  logic [3:0]       op_code,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] pat,
  input  logic [WIDTH-1:0] ins_val,
  output logic [WIDTH-1:0] result
);
  import bitop_pkg::*;
  always_comb begin
    unique case (op_code)
      OP_SET:          result = cur | pat;
      OP_FLIP, OP_DIFF: result = cur ^ pat;
      OP_CLR:          result = cur & ~pat;
      OP_MASK:         result = cur & pat;
      OP_INS:          result = (cur & pat) | ins_val;
      default:         result = cur;
    endcase
  end
endmodule

// File: rtl/bitop_shift_unit.sv
module bitop_shift_unit #(
  parameter int WIDTH = 16
) (
  input  logic [3:0]       op_code,
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] result,
  output logic             ovf_next
);
  import bitop_pkg::*;
  logic             go_left;
  fill_e            fill;
  logic             in_bit;
  logic [WIDTH-1:0] left_v, right_v;

  always_comb begin
    go_left = 1'b0;
    fill    = FILL_ZERO;
    unique case (op_code)
      OP_SHL: begin go_left = 1'b1; fill = FILL_ZERO; end
      OP_SHR: begin go_left = 1'b0; fill = FILL_ZERO; end
      OP_ROL: begin go_left = 1'b1; fill = FILL_WRAP; end
      OP_ROR: begin go_left = 1'b0; fill = FILL_WRAP; end
      OP_ASL: begin go_left = 1'b1; fill = FILL_ZERO; end
      OP_ASR: begin go_left = 1'b0; fill = FILL_SIGN; end
      default: begin go_left = 1'b0; fill = FILL_ZERO; end
    endcase
  end

  always_comb begin
    unique case (fill)
      FILL_WRAP: in_bit = go_left ? cur[WIDTH-1] : cur[0];
      FILL_SIGN: in_bit = cur[WIDTH-1];
      default:   in_bit = 1'b0;
    endcase
  end

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      if (i == 0) begin : g_lsb
        assign left_v[i] = in_bit;
      end else begin : g_mid_l
        assign left_v[i] = cur[i-1];
      end
      if (i == WIDTH-1) begin : g_msb
        assign right_v[i] = in_bit;
      end else begin : g_mid_r
        assign right_v[i] = cur[i+1];
      end
    end
  endgenerate

  assign result   = go_left ? left_v : right_v;
  assign ovf_next = (op_code == OP_ASL) && (cur[WIDTH-1] ^ cur[WIDTH-2]);
endmodule

// File: rtl/bitop_shift_reg.sv
module bitop_shift_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic [3:0]       op_code,
  input  logic [WIDTH-1:0] load_val,
  input  logic [WIDTH-1:0] pat,
  input  logic [WIDTH-1:0] ins_val,
  output logic [WIDTH-1:0] acc,
  output logic             ovf
);
  import bitop_pkg::*;
  localparam logic [3:0] FIRST_SHIFT = OP_SHL;
  localparam logic [3:0] LAST_SHIFT  = OP_ASR;

  logic [WIDTH-1:0] logic_res, shift_res, nxt;
  logic             shift_ovf, is_shift;

  bitop_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .op_code(op_code), .cur(acc), .pat(pat), .ins_val(ins_val), .result(logic_res));
  bitop_shift_unit #(.WIDTH(WIDTH)) u_shift (
    .op_code(op_code), .cur(acc), .result(shift_res), .ovf_next(shift_ovf));

  assign is_shift = (op_code >= FIRST_SHIFT) && (op_code <= LAST_SHIFT);

  always_comb begin
    if (op_code == OP_LOAD) nxt = load_val;
    else if (is_shift)      nxt = shift_res;
    else                    nxt = logic_res;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      ovf <= 1'b0;
    end else if (step_en) begin
      acc <= nxt;
      ovf <= shift_ovf;
    end
  end
endmodule

// File: rtl/bitop_shift_reg_chk.sv
module bitop_shift_reg_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             step_en,
  input logic [3:0]       op_code,
  input logic [WIDTH-1:0] load_val,
  input logic [WIDTH-1:0] pat,
  input logic [WIDTH-1:0] ins_val,
  input logic [WIDTH-1:0] acc,
  input logic             ovf
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (acc == '0 && !ovf));
  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(acc) && $stable(ovf)));
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (step_en && op_code == 4'd0) |=> acc == $past(load_val));
  assert_insert_R4: assert property (@(posedge clk) disable iff (rst)
    (step_en && op_code == 4'd6) |=> acc == (($past(acc) & $past(pat)) | $past(ins_val)));
  assert_rotl_R6: assert property (@(posedge clk) disable iff (rst)
    (step_en && op_code == 4'd9) |=> acc == {$past(acc[WIDTH-2:0]), $past(acc[WIDTH-1])});
  assert_asr_sign_R7: assert property (@(posedge clk) disable iff (rst)
    (step_en && op_code == 4'd12) |=> acc[WIDTH-1] == $past(acc[WIDTH-1]));
  assert_ovf_R8: assert property (@(posedge clk) disable iff (rst)
    (step_en && op_code == 4'd11) |=> ovf == ($past(acc[WIDTH-1]) ^ $past(acc[WIDTH-2])));
  assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (step_en && op_code != 4'd11) |=> !ovf);
  assert_unused_R9: assert property (@(posedge clk) disable iff (rst)
    (step_en && op_code >= 4'd13) |=> $stable(acc));
endmodule

bind bitop_shift_reg bitop_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/bitop_shift_reg_tb.sv
module bitop_shift_reg_tb_top;
  localparam int W = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst = 1, step_en = 0;
  logic [3:0] op_code = 0;
  logic [W-1:0] load_val = 0, pat = 0, ins_val = 0;
  logic [W-1:0] acc;
  logic ovf;
  int n_chk = 0, n_fail = 0;
  logic [W-1:0] m_acc;
  logic m_ovf;

  bitop_shift_reg #(.WIDTH(W)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] model(input logic [3:0] op, input logic [W-1:0] a,
      input logic [W-1:0] p, input logic [W-1:0] v, input logic [W-1:0] ld);
    case (op)
      0: return ld;
      1: return a | p;
      2, 5: return a ^ p;
      3: return a & ~p;
      4: return a & p;
      6: return (a & p) | v;
      7, 11: return a << 1;
      8: return a >> 1;
      9: return {a[W-2:0], a[W-1]};
      10: return {a[0], a[W-1:1]};
      12: return {a[W-1], a[W-1:1]};
      default: return a;
    endcase
  endfunction

  function automatic string tag(input logic [3:0] op, input logic en);
    if (!en) return "R1";
    case (op)
      0, 1, 3: return "R2";
      2, 4, 5: return "R3";
      6: return "R4";
      7, 8: return "R5";
      9, 10: return "R6";
      11, 12: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string r, input logic [W-1:0] a, input logic o);
    n_chk++;
    if (acc !== a || ovf !== o) begin
      n_fail++;
      $display("FAIL %s: acc=%h ovf=%b expected acc=%h ovf=%b", r, acc, ovf, a, o);
    end
  endtask

  task automatic step(input logic en, input logic [3:0] op, input logic [W-1:0] ld,
      input logic [W-1:0] p, input logic [W-1:0] v);
    step_en = en; op_code = op; load_val = ld; pat = p; ins_val = v;
    if (en) begin
      m_ovf = (op == 11) && (m_acc[W-1] ^ m_acc[W-2]);
      m_acc = model(op, m_acc, p, v, ld);
    end
    @(posedge clk); #1;
    check(tag(op, en), m_acc, m_ovf);
    if (en && op == 11) check("R8", m_acc, m_ovf);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: acc=%h ovf=%b expected completion", acc, ovf);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(posedge clk); #1;
    rst = 0;
    m_acc = 0; m_ovf = 0;
    check("R1", 16'h0, 1'b0);
    // directed examples
    step(1, 0, 16'h000C, 0, 0);
    step(1, 1, 0, 16'h000A, 0);        // R2 -> 0x000E
    step(1, 0, 16'h000C, 0, 0);
    step(1, 2, 0, 16'h000A, 0);        // R3 -> 0x0006
    step(1, 0, 16'h000C, 0, 0);
    step(1, 3, 0, 16'h000A, 0);        // R2 -> 0x0004
    step(1, 0, 16'h000C, 0, 0);
    step(1, 4, 0, 16'h000A, 0);        // R3 -> 0x0008
    step(1, 0, 16'hD8B1, 0, 0);
    step(1, 6, 0, 16'hFFF0, 16'h000A); // R4 -> 0xD8BA
    if (acc !== 16'hD8BA) begin n_fail++; $display("FAIL R4: acc=%h expected d8ba", acc); end
    n_chk++;
    // boundary shifts
    step(1, 0, 16'h8001, 0, 0);
    step(1, 9, 0, 0, 0);               // R6 rol -> 0x0003
    step(1, 0, 16'h8001, 0, 0);
    step(1, 10, 0, 0, 0);              // R6 ror -> 0xC000
    step(1, 0, 16'h8001, 0, 0);
    step(1, 7, 0, 0, 0);               // R5
    step(1, 0, 16'h8001, 0, 0);
    step(1, 8, 0, 0, 0);               // R5
    step(1, 0, 16'h8000, 0, 0);
    step(1, 12, 0, 0, 0);              // R7 -> 0xC000
    step(1, 0, 16'h4000, 0, 0);
    step(1, 11, 0, 0, 0);              // R8 overflow set
    step(0, 1, 0, 16'hFFFF, 0);        // R1 hold, flag kept
    step(1, 14, 0, 0, 0);              // R9 hold, R8 flag clears
    step(1, 0, 16'hC000, 0, 0);
    step(1, 11, 0, 0, 0);              // R8 no overflow
    step(1, 5, 0, 16'h1234, 0);
    // random
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] op = 4'($urandom_range(0, 15));
      step(($urandom_range(0, 7) != 0), op, 16'($urandom), 16'($urandom), 16'($urandom));
    end
    rst = 1; @(posedge clk); #1; rst = 0;
    m_acc = 0; m_ovf = 0;
    check("R1", 16'h0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule